// File: doc/BRIEF.md
# Single-Adder Arithmetic-Logic Unit

This block computes eight arithmetic and logic functions of two unsigned operands using exactly one ripple adder. A bank of identical per-bit conditioning cells sits in front of the adder. Each cell is steered by a 3-bit opcode and turns its operand bit pair into the two adder input bits. A separate small cell derives the adder carry-in from the opcode alone. The requested result then appears at the adder sum output, and no separate functional units or output multiplexer are needed.

The logic functions (AND, OR, XOR, NOT) are formed inside the conditioning cells. They pass through the adder against a zero addend with carry-in clear, so the sum equals the cell output exactly and the carry-out is zero. A combinational sum and carry-out are always visible. A result register captures the sum when its load input is high and otherwise keeps its value.

Top module: `xalu_top`

## Requirements
- R1: Opcode 3'b000 yields sum = (A + B) mod 2^W, with carry_out equal to bit W of the full sum.
- R2: Opcode 3'b001 yields sum = (A - B) mod 2^W, formed as A + ~B + 1, with carry_out = 1 exactly when A >= B.
- R3: Opcode 3'b010 yields sum = (A + 1) mod 2^W, with carry_out = 1 only when A is all ones.
- R4: Opcode 3'b011 yields sum = A with carry_out = 0.
- R5: Opcode 3'b100 yields sum = A & B with carry_out = 0.
- R6: Opcode 3'b101 yields sum = A | B with carry_out = 0.
- R7: Opcode 3'b110 yields sum = A ^ B with carry_out = 0.
- R8: Opcode 3'b111 yields sum = ~A with carry_out = 0; B has no effect.
- R9: At the rising clock edge where load is 1, result_q takes the current sum and result_co_q takes carry_out; where load is 0 both keep their value.
- R10: While rst_n is low, result_q and result_co_q are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Opcode (bit 2 = x, bit 1 = y, bit 0 = z) |
| opa | input | W (8) | Operand A |
| opb | input | W (8) | Operand B |
| load | input | 1 | Result register load enable |
| sum | output | W (8) | Combinational adder output |
| carry_out | output | 1 | Combinational adder carry-out |
| result_q | output | W (8) | Registered result |
| result_co_q | output | 1 | Registered carry-out |

## Verification
Every opcode is driven with the corner operands 0x00, 0xFF, 0x7F and 0x80 in all pairings. These pairings separate carry rippling through every bit, a borrow at equal operands, and the increment wrap from all ones. A sweep of pseudo-random operands then guards against a wrong per-bit mapping that the corners happen to mask. The logic opcodes are checked for a zero carry-out, and NOT A is checked under changing B. The register is checked for capture while load is high and for hold while load is low and the operands change.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_PASS = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOT  = 3'b111
  } xalu_op_e;

  typedef struct packed {
    logic ia;
    logic ib;
  } bit_pair_t;
endpackage

// File: rtl/xalu_bit_cond.sv
module xalu_bit_cond
  import xalu_pkg::*;
(
  input  logic [2:0] op,
  input  logic       a_bit,
  input  logic       b_bit,
  output bit_pair_t  pair
);
  always_comb begin
    pair.ia = a_bit;
    pair.ib = 1'b0;
    unique case (op)
      OP_ADD:  pair.ib = b_bit;
      OP_SUB:  pair.ib = ~b_bit;
      OP_INC:  pair.ib = 1'b0;
      OP_PASS: pair.ib = 1'b0;
      OP_AND:  pair.ia = a_bit & b_bit;
      OP_OR:   pair.ia = a_bit | b_bit;
      OP_XOR:  pair.ia = a_bit ^ b_bit;
      OP_NOT:  pair.ia = ~a_bit;
      default: pair.ib = 1'b0;
    endcase
  end
endmodule

// File: rtl/xalu_cin_gen.sv
module xalu_cin_gen
  import xalu_pkg::*;
(
  input  logic [2:0] op,
  output logic       cin
);
  always_comb begin
    unique case (op)
      OP_SUB, OP_INC: cin = 1'b1;
      default:        cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/xalu_ripple_add.sv
module xalu_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] ia,
  input  logic [W-1:0] ib,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = ia[i] ^ ib[i] ^ c[i];
    assign c[i+1] = (ia[i] & ib[i]) | (c[i] & (ia[i] ^ ib[i]));
  end
  assign cout = c[W];
endmodule

// File: rtl/xalu_top.sv
module xalu_top
  import xalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         load,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic [W-1:0] result_q,
  output logic         result_co_q
);
  logic [W-1:0] ia_vec;
  logic [W-1:0] ib_vec;
  logic         cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    bit_pair_t p;
    xalu_bit_cond u_cell (
      .op    (op),
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .pair  (p)
    );
    assign ia_vec[i] = p.ia;
    assign ib_vec[i] = p.ib;
  end

  xalu_cin_gen u_cin (
    .op  (op),
    .cin (cin)
  );

  xalu_ripple_add #(.W(W)) u_add (
    .ia   (ia_vec),
    .ib   (ib_vec),
    .cin  (cin),
    .s    (sum),
    .cout (carry_out)
  );

  logic [W-1:0] res_d;
  logic         co_d;

  always_comb begin
    res_d = result_q;
    co_d  = result_co_q;
    if (load) begin
      res_d = sum;
      co_d  = carry_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q    <= '0;
      result_co_q <= 1'b0;
    end else begin
      result_q    <= res_d;
      result_co_q <= co_d;
    end
  end
endmodule

// File: rtl/xalu_checker.sv
module xalu_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         load,
  input logic [W-1:0] sum,
  input logic         carry_out,
  input logic [W-1:0] result_q,
  input logic         result_co_q
);
  a_r5_and_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b100) |-> (carry_out == 1'b0 && sum == (opa & opb)));

  a_r6_or_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b101) |-> (carry_out == 1'b0 && sum == (opa | opb)));

  a_r7_xor_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b110) |-> (carry_out == 1'b0 && sum == (opa ^ opb)));

  a_r8_not_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b111) |-> (carry_out == 1'b0 && sum == ~opa));

  a_r4_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b011) |-> (carry_out == 1'b0 && sum == opa));

  a_r1_add: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b000) |-> ({carry_out, sum} == ({1'b0, opa} + {1'b0, opb})));

  a_r2_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b001) |-> (carry_out == (opa >= opb) && sum == W'(opa - opb)));

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b010) |-> ({carry_out, sum} == ({1'b0, opa} + 1'b1)));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (result_q == $past(sum) && result_co_q == $past(carry_out)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(result_q) && $stable(result_co_q)));

  always_comb begin
    if (!rst_n) begin
      a_r10_reset: assert (result_q == '0 && result_co_q == 1'b0);
    end
  end
endmodule

bind xalu_top xalu_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op          (op),
  .opa         (opa),
  .opb         (opb),
  .load        (load),
  .sum         (sum),
  .carry_out   (carry_out),
  .result_q    (result_q),
  .result_co_q (result_co_q)
);

// File: tb/tb_xalu_top.sv
module tb_xalu_top;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [2:0]   op;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         load;
  logic [W-1:0] sum;
  logic         carry_out;
  logic [W-1:0] result_q;
  logic         result_co_q;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  xalu_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb), .load(load),
    .sum(sum), .carry_out(carry_out), .result_q(result_q), .result_co_q(result_co_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W:0] ref_model(input logic [2:0] o, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (o)
      3'b000: return {1'b0, a} + {1'b0, b};
      3'b001: return {1'b0, a} + {1'b0, ~b} + 1;
      3'b010: return {1'b0, a} + 1;
      3'b011: return {1'b0, a};
      3'b100: return {1'b0, a & b};
      3'b101: return {1'b0, a | b};
      3'b110: return {1'b0, a ^ b};
      default: return {1'b0, ~a};
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (op=%b a=%h b=%h)", req, act, exp, op, opa, opb);
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply_and_check(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op = o; opa = a; opb = b;
    #1;
    check(req_of(o), {carry_out, sum}, ref_model(o, a, b));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; load = 1'b1; op = 3'b000; opa = 8'hFF; opb = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {result_co_q, result_q}, '0);
    rst_n = 1'b1;
    load = 1'b0;
  endtask

  task automatic test_corners();
    logic [W-1:0] c [4];
    c[0] = 8'h00; c[1] = 8'hFF; c[2] = 8'h7F; c[3] = 8'h80;
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply_and_check(3'(o), c[i], c[j]);
    // R2 borrow at equal operands, R3 wrap from all ones
    apply_and_check(3'b001, 8'h55, 8'h55);
    check("R2", {7'b0, carry_out}, 8'h01);
    apply_and_check(3'b010, 8'hFF, 8'h00);
    check("R3", {carry_out, sum}, 9'h100);
  endtask

  task automatic test_random();
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply_and_check(lfsr[18:16], lfsr[7:0], lfsr[15:8]);
    end
  endtask

  task automatic test_not_ignores_b();
    logic [W:0] first;
    apply_and_check(3'b111, 8'h3C, 8'h00);
    first = {carry_out, sum};
    apply_and_check(3'b111, 8'h3C, 8'hA7);
    check("R8", {carry_out, sum}, first);
  endtask

  task automatic test_register();
    @(negedge clk);
    op = 3'b000; opa = 8'hF0; opb = 8'h20; load = 1'b1;
    @(negedge clk);
    check("R9", {result_co_q, result_q}, 9'h110);
    load = 1'b0; op = 3'b100; opa = 8'h0F; opb = 8'h0F;
    repeat (2) @(negedge clk);
    check("R9", {result_co_q, result_q}, 9'h110);
    load = 1'b1;
    @(negedge clk);
    check("R9", {result_co_q, result_q}, 9'h00F);
    load = 1'b0;
  endtask

  initial begin
    op = '0; opa = '0; opb = '0; load = 1'b0; rst_n = 1'b0;
    test_reset();
    test_corners();
    test_not_ignores_b();
    test_random();
    test_register();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule